// File: doc/BRIEF.md
# Synchronized Sub-Interval Sweep Generator

This block produces a digital sawtooth from a fast counting clock and keeps it in step with an external synchronization pulse train. The time between two rising edges of the sync input is one sampling interval. The block measures that interval in counting-clock cycles and splits the next interval into n equal sub-intervals. At each sub-interval boundary it restarts the sweep count and raises a one-cycle strobe together with the new sub-interval index. A downstream converter or comparator uses the count as the master ramp.

The division factor n is chosen with a small power-of-two code and takes effect on the next sync edge. The sub-interval length comes from the interval that has just ended, so a change of sync period shows up one interval later. Any remainder cycles stay in the last sub-interval. The outputs run freely and have no back-pressure, because a sweep cannot pause.

Top module: `sync_sweep_gen`

## Requirements
- R1: While reset is asserted (rst_n low), sweep_count is 0, sub_index is 0, and sub_strobe and sweep_valid are low.
- R2: sweep_valid goes high at the second rising edge of sync_in after reset (the first whole interval has been measured) and then stays high.
- R3: One clock after a sync_in rising edge is sampled, sweep_count is 0 and sub_index is 0. sub_strobe is high in that cycle if sweep_valid is high after the edge.
- R4: Between restarts, sweep_count goes up by one each clock and holds at all ones (16'hFFFF with defaults) once it gets there.
- R5: Let P be the number of clocks between the last two sync rising edges and n the latched factor. Then L = floor(P/n). When valid, sub-interval k (k = 0..n-1) starts L*k clocks after the sync restart. At that point the count shows 0, sub_index shows k and sub_strobe is high for one cycle. Index n-1 lasts until the next sync edge and absorbs the remainder.
- R6: div_log2 selects n = 2^div_log2 (code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). It is sampled only on a sync rising edge. A change at any other time does not affect the current interval.
- R7: If L is 0 (P shorter than n), no boundaries occur inside the interval. Only the sync restart strobes, and sub_index stays 0.
- R8: While sweep_valid is low, sub_strobe stays low, sub_index stays 0, and the count restarts only on sync edges.
- R9: Only a rising edge of sync_in counts. A sync_in level held high for several clocks restarts the sweep once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | External synchronization pulse; rising edge marks an interval start |
| div_log2 | input | 2 | Log2 of the division factor n, sampled on sync edges |
| sweep_count | output | 16 | Current sweep count within the sub-interval |
| sub_strobe | output | 1 | One-cycle marker at each sub-interval start |
| sub_index | output | 3 | Index of the current sub-interval |
| sweep_valid | output | 1 | High once an interval length has been measured |

## Verification
The hardest states to reach are sweep-count saturation and a zero-length sub-interval. Saturation needs more than 65535 clocks with no sync edge, so the bench holds sync low for that long right after reset, before any interval is measured. A zero-length sub-interval appears only when a very short interval is followed by an interval with a large n, so the vector table places a 5-clock interval immediately before an interval with n = 8. A held sync level and a factor change in mid-interval are also covered, and the outputs are compared cycle by cycle.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int SWP_CNT_W_DEF    = 16;
  localparam int SWP_MAX_LOG2_DEF = 3;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SYNC = 2'd1,
    EV_SUB  = 2'd2
  } sweep_evt_e;
endpackage

// File: rtl/swp_edge_detect.sv
module swp_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/swp_period_meter.sv
module swp_period_meter #(
  parameter int CNT_W    = 16,
  parameter int MAX_LOG2 = 3,
  parameter int DIV_W    = 2,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [DIV_W-1:0] div_code,
  output logic             valid,
  output logic             arm,
  output logic [CNT_W-1:0] sub_len,
  output logic [IDX_W-1:0] last_idx
);
  localparam logic [IDX_W-1:0] ALL_ONES = '1;
  localparam int CODE_MAX = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] period_new;
  logic [DIV_W-1:0] dsel;
  logic             have_first;

  generate
    if (CODE_MAX > MAX_LOG2) begin : g_clamp
      always_comb dsel = (div_code > DIV_W'(MAX_LOG2)) ? DIV_W'(MAX_LOG2) : div_code;
    end else begin : g_direct
      always_comb dsel = div_code;
    end
  endgenerate

  always_comb begin
    period_new = (per_cnt == '1) ? per_cnt : per_cnt + CNT_W'(1);
  end

  assign arm = valid | have_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt    <= '0;
      have_first <= 1'b0;
      valid      <= 1'b0;
      sub_len    <= '0;
      last_idx   <= '0;
    end else if (rise) begin
      per_cnt    <= '0;
      have_first <= 1'b1;
      valid      <= arm;
      sub_len    <= period_new >> dsel;
      last_idx   <= ALL_ONES >> (DIV_W'(MAX_LOG2) - dsel);
    end else if (per_cnt != '1) begin
      per_cnt <= per_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/swp_sub_sweep.sv
module swp_sub_sweep
  import sweep_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             valid,
  input  logic             arm,
  input  logic [CNT_W-1:0] sub_len,
  input  logic [IDX_W-1:0] last_idx,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] index,
  output logic             strobe
);
  sweep_evt_e ev;

  always_comb begin
    if (rise)
      ev = EV_SYNC;
    else if (valid && (sub_len != '0) && (index != last_idx) &&
             (count == sub_len - CNT_W'(1)))
      ev = EV_SUB;
    else
      ev = EV_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      index  <= '0;
      strobe <= 1'b0;
    end else begin
      case (ev)
        EV_SYNC: begin
          count  <= '0;
          index  <= '0;
          strobe <= arm;
        end
        EV_SUB: begin
          count  <= '0;
          index  <= index + IDX_W'(1);
          strobe <= 1'b1;
        end
        default: begin
          if (count != '1) count <= count + CNT_W'(1);
          strobe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sync_sweep_gen.sv
module sync_sweep_gen
  import sweep_pkg::*;
#(
  parameter int CNT_W    = SWP_CNT_W_DEF,
  parameter int MAX_LOG2 = SWP_MAX_LOG2_DEF,
  localparam int DIV_W   = (MAX_LOG2 < 1) ? 1 : $clog2(MAX_LOG2 + 1),
  localparam int IDX_W   = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [DIV_W-1:0] div_log2,
  output logic [CNT_W-1:0] sweep_count,
  output logic             sub_strobe,
  output logic [IDX_W-1:0] sub_index,
  output logic             sweep_valid
);
  logic             rise;
  logic             arm;
  logic [CNT_W-1:0] sub_len;
  logic [IDX_W-1:0] last_idx;

  swp_edge_detect edge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (sync_in),
    .rise     (rise)
  );

  swp_period_meter #(
    .CNT_W    (CNT_W),
    .MAX_LOG2 (MAX_LOG2),
    .DIV_W    (DIV_W),
    .IDX_W    (IDX_W)
  ) meter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .div_code (div_log2),
    .valid    (sweep_valid),
    .arm      (arm),
    .sub_len  (sub_len),
    .last_idx (last_idx)
  );

  swp_sub_sweep #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) sweep_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .valid    (sweep_valid),
    .arm      (arm),
    .sub_len  (sub_len),
    .last_idx (last_idx),
    .count    (sweep_count),
    .index    (sub_index),
    .strobe   (sub_strobe)
  );
endmodule

// File: rtl/sync_sweep_gen_chk.sv
module sync_sweep_gen_chk #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_in,
  input logic [CNT_W-1:0] sweep_count,
  input logic             sub_strobe,
  input logic [IDX_W-1:0] sub_index,
  input logic             sweep_valid
);
  logic sync_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_prev <= 1'b0;
    else        sync_prev <= sync_in;
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_valid |=> sweep_valid); // R2

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !sync_prev) |=> (sweep_count == '0 && sub_index == '0)); // R3

  AST_SYNC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !sync_prev && sweep_valid) |=> sub_strobe); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_count != '1) |=> (sweep_count == '0 ||
                             sweep_count == $past(sweep_count) + CNT_W'(1))); // R4

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_count == '1) |=> (sweep_count == '1 || sweep_count == '0)); // R4

  AST_STROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sub_strobe |-> sweep_count == '0); // R5

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_strobe && sub_index != '0) |-> sub_index == $past(sub_index) + IDX_W'(1)); // R5

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_strobe |-> $stable(sub_index)); // R5

  AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_valid |-> (!sub_strobe && sub_index == '0)); // R8
endmodule

bind sync_sweep_gen sync_sweep_gen_chk #(
  .CNT_W (CNT_W),
  .IDX_W (IDX_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_in     (sync_in),
  .sweep_count (sweep_count),
  .sub_strobe  (sub_strobe),
  .sub_index   (sub_index),
  .sweep_valid (sweep_valid)
);

// File: tb/sync_sweep_gen_tb_top.sv
`timescale 1ns/1ps
module sync_sweep_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0;
  logic [1:0]  div_log2 = 2'd0;
  logic [15:0] sweep_count;
  logic        sub_strobe;
  logic [2:0]  sub_index;
  logic        sweep_valid;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int last_p = 0;
  bit done = 1'b0;

  // rows: {interval length P, div code, sync high cycles}
  localparam int NVEC = 11;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd40, 8'd2, 8'd1},  // first edge, not yet valid (R8)
    {16'd40, 8'd2, 8'd1},  // L=10, n=4 (R2, R5)
    {16'd64, 8'd3, 8'd1},  // L=5, n=8, long tail in last slot
    {16'd64, 8'd3, 8'd1},  // L=8, n=8
    {16'd36, 8'd0, 8'd1},  // n=1, no inner boundary
    {16'd36, 8'd1, 8'd1},  // n=2, L=18
    {16'd37, 8'd2, 8'd1},  // L=9, remainder in last slot
    {16'd37, 8'd2, 8'd3},  // held sync level (R9)
    {16'd5,  8'd3, 8'd1},  // short interval, L=4
    {16'd20, 8'd3, 8'd1},  // L=5>>3=0 (R7)
    {16'd24, 8'd2, 8'd1}   // L=5
  };

  sync_sweep_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_in     (sync_in),
    .div_log2    (div_log2),
    .sweep_count (sweep_count),
    .sub_strobe  (sub_strobe),
    .sub_index   (sub_index),
    .sweep_valid (sweep_valid)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_interval(input int p, input int d, input int h, input int alt_d);
    int lsub;
    int n;
    int k;
    int cnt;
    bit strb;
    bit vld;
    string tag;
    logic [19:0] exp_v;
    logic [19:0] act_v;
    rises++;
    vld = (rises >= 2);
    lsub = last_p >> d;
    n = 1 << d;
    sync_in = 1'b1;
    div_log2 = 2'(d);
    for (int j = 0; j < p; j++) begin
      @(negedge clk);
      if (j == h - 1) sync_in = 1'b0;
      if (alt_d >= 0 && j == 3) div_log2 = 2'(alt_d);
      if (!vld) begin
        k = 0; cnt = j; strb = 1'b0; tag = "R8";
      end else if (lsub == 0) begin
        k = 0; cnt = j; strb = (j == 0); tag = "R7";
      end else begin
        k = j / lsub;
        if (k > n - 1) k = n - 1;
        cnt = j - k * lsub;
        strb = (j == k * lsub);
        tag = (j == 0) ? "R3" : "R5";
      end
      if (alt_d >= 0) tag = "R6";
      if (h > 1) tag = "R9";
      exp_v = {16'(cnt), 3'(k), strb};
      act_v = {sweep_count, sub_index, sub_strobe};
      check(act_v == exp_v, tag, 32'(act_v), 32'(exp_v));
      if (j == 0) check(sweep_valid == vld, "R2", 32'(sweep_valid), 32'(vld));
    end
    last_p = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sweep_count == 16'd0, "R1", 32'(sweep_count), 32'd0);
    check(sub_index == 3'd0, "R1", 32'(sub_index), 32'd0);
    check(sub_strobe == 1'b0, "R1", 32'(sub_strobe), 32'd0);
    check(sweep_valid == 1'b0, "R1", 32'(sweep_valid), 32'd0);
    rst_n = 1'b1;
    // R4: saturation with no sync edge
    repeat (66000) @(negedge clk);
    check(sweep_count == 16'hFFFF, "R4", 32'(sweep_count), 32'hFFFF);
    check(sweep_valid == 1'b0, "R8", 32'(sweep_valid), 32'd0);
    check(sub_strobe == 1'b0, "R8", 32'(sub_strobe), 32'd0);
    // vector table
    for (int v = 0; v < NVEC; v++) begin
      run_interval(int'(VEC[v][31:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), -1);
    end
    // R6: factor change in mid-interval has no effect
    run_interval(24, 2, 1, 0);
    run_interval(24, 2, 1, -1);
    check(sweep_valid == 1'b1, "R2", 32'(sweep_valid), 32'd1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule